// File: doc/BRIEF.md
# LED Matrix Open/Short Fault Scanner

This block runs one diagnostic pass over a multiplexed LED matrix each time firmware arms it. Firmware writes a two-bit detection mode. Moving that field from the off code to any other code starts a pass. The block then follows the matrix scanner through its frame strobe and row index. It lets one full frame go by so the outputs can settle. During the next frame it captures one word of per-sink comparator flags for each row. Open flags or short flags are used, as the mode selects.

The captured words go into a status bank that is read a byte at a time. Each row gets two bytes, with a 1 marking a faulty dot. When the pass ends, a done flag rises. The results then stay frozen until firmware returns the mode to off and arms the block again. When the sink pin nearest the top is reused as a ninth row driver, the bit for that sink is always stored as 0.

Top module: `led_fault_scan`

## Requirements
- R1: Mode code 01 and code 11 run an open-circuit pass that uses `open_flags_i`. Code 10 runs a short-circuit pass that uses `short_flags_i`. Code 00 runs no pass. Flag bit i belongs to sink i+1.
- R2: A pass is armed only when the mode changes from 00 to a non-zero code. The mode register reads 00 after reset. Holding a non-zero code does not re-arm the block, and neither does changing from one non-zero code to another.
- R3: Once armed, the block ignores the frame that begins at the first `frame_i` pulse. It samples the frame that begins at the second pulse. `done_o` goes high in the cycle after the third pulse and stays low before that.
- R4: The word stored for a row is the selected flag word on the last cycle in which `row_idx_i` holds that row during the sampled frame.
- R5: Read data appears one cycle after `rd_addr_i` is presented. Byte address 2r holds sinks 16..9 of row r, with bit 7 for sink 16. Byte address 2r+1 holds sinks 8..1, with bit 0 for sink 1. Addresses 18 and above read 0.
- R6: The whole bank reads 0 after reset and again from the arming cycle of each pass. Rows that are not scanned in the sampled frame read 0.
- R7: After `done_o` rises, later flag values and later frames leave every status byte unchanged until the next pass is armed.
- R8: While `nine_row_i` is high, the stored bit for sink 16 is 0.
- R9: `done_o` is low after reset, falls when a pass is armed, and stays high from completion until the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Detection mode field |
| nine_row_i | input | 1 | The top sink pin is reused as row 9 |
| row_idx_i | input | ROW_W | Index of the row the scanner is driving |
| frame_i | input | 1 | One-cycle pulse in the first cycle of row 0 of each frame |
| open_flags_i | input | SINKS | Per-sink open comparator flags |
| short_flags_i | input | SINKS | Per-sink short comparator flags |
| rd_addr_i | input | ADDR_W | Status byte address |
| rd_data_o | output | 8 | Status byte read back |
| done_o | output | 1 | The pass has completed |

## Verification
The bench uses the default build of 16 sinks and 9 rows. That gives an 18-byte bank behind a 5-bit read address, so all 14 unmapped addresses can be read. It also means the row-9 reuse of sink 16 is exercised both with and without the mask. Row dwell times are random, from two to four cycles, and the flags change on every cycle. A design that samples any cycle other than the last one of a row therefore stores the wrong word. Passes with only some rows scanned show that the unscanned rows read back as cleared.

// File: rtl/ledfault_pkg.sv
package ledfault_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SETTLE,
    ST_SAMPLE,
    ST_DONE
  } seq_state_t;

  typedef enum logic {
    KIND_OPEN,
    KIND_SHORT
  } fault_kind_t;

  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_SHORT = 2'b10;
endpackage

// File: rtl/lf_arm_detect.sv
module lf_arm_detect
  import ledfault_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode_i,
  output logic        arm_o,
  output fault_kind_t kind_o
);
  logic [1:0] mode_q;
  logic       leaves_off;

  // A pass starts only when the field leaves the off code
  assign leaves_off = (mode_q == MODE_OFF) && (mode_i != MODE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
      arm_o  <= 1'b0;
      kind_o <= KIND_OPEN;
    end else begin
      mode_q <= mode_i;
      arm_o  <= leaves_off;
      if (leaves_off)
        kind_o <= (mode_i == MODE_SHORT) ? KIND_SHORT : KIND_OPEN;
    end
  end
endmodule

// File: rtl/lf_frame_seq.sv
module lf_frame_seq
  import ledfault_pkg::*;
#(
  parameter int SINKS = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  fault_kind_t      kind_i,
  input  logic             nine_row_i,
  input  logic [ROW_W-1:0] row_idx_i,
  input  logic             frame_i,
  input  logic [SINKS-1:0] open_flags_i,
  input  logic [SINKS-1:0] short_flags_i,
  output logic             clr_o,
  output logic             we_o,
  output logic [ROW_W-1:0] waddr_o,
  output logic [SINKS-1:0] wdata_o,
  output logic             done_o
);
  localparam logic [SINKS-1:0] TOP_SINK = {1'b1, {(SINKS-1){1'b0}}};

  seq_state_t       state_q;
  logic [ROW_W-1:0] hold_row_q;
  logic [SINKS-1:0] hold_flags_q;
  logic [SINKS-1:0] keep_mask;
  logic [SINKS-1:0] flags_sel;
  logic             capture;
  logic             commit;

  assign keep_mask = nine_row_i ? ~TOP_SINK : '1;
  assign flags_sel = ((kind_i == KIND_SHORT) ? short_flags_i : open_flags_i) & keep_mask;

  // Keep the newest word of the current row. The strobe cycle that opens
  // the sampled frame is row 0 of that frame.
  assign capture = ((state_q == ST_SAMPLE) && !frame_i) ||
                   ((state_q == ST_SETTLE) && frame_i);

  // Write the held word back when its row ends (row change or next frame)
  assign commit = (state_q == ST_SAMPLE) && !arm_i &&
                  (frame_i || (row_idx_i != hold_row_q));

  assign clr_o   = arm_i;
  assign we_o    = commit;
  assign waddr_o = hold_row_q;
  assign wdata_o = hold_flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else if (arm_i) begin
      state_q <= ST_ARMED;
      done_o  <= 1'b0;
    end else begin
      case (state_q)
        ST_ARMED:  if (frame_i) state_q <= ST_SETTLE;
        ST_SETTLE: if (frame_i) state_q <= ST_SAMPLE;
        ST_SAMPLE: if (frame_i) begin
          state_q <= ST_DONE;
          done_o  <= 1'b1;
        end
        default:   state_q <= state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_row_q   <= '0;
      hold_flags_q <= '0;
    end else if (capture) begin
      hold_row_q   <= row_idx_i;
      hold_flags_q <= flags_sel;
    end
  end
endmodule

// File: rtl/lf_status_bank.sv
module lf_status_bank #(
  parameter int SINKS  = 16,
  parameter int ROWS   = 9,
  parameter int ROW_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  waddr_i,
  input  logic [SINKS-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int BPR   = (SINKS + 7) / 8;
  localparam int BYTES = ROWS * BPR;
  localparam int SEL_W = (BPR > 1) ? $clog2(BPR) : 1;

  logic [SINKS-1:0] mem [ROWS];
  logic [ROWS-1:0]  valid_q;
  logic [SINKS-1:0] word_q;
  logic             hit_q;
  logic [SEL_W-1:0] sel_q;
  logic             in_range;
  logic [ROW_W-1:0] rrow;
  logic [SEL_W-1:0] sel_next;
  logic [BPR*8-1:0] padded;

  // Payload array: no reset and one write port, so block RAM can be used
  always_ff @(posedge clk) begin
    if (we_i && (32'(waddr_i) < ROWS))
      mem[waddr_i] <= wdata_i;
  end

  // Per-row valid bits give a one-cycle clear of the whole bank
  for (genvar g = 0; g < ROWS; g++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst || clr_i)
        valid_q[g] <= 1'b0;
      else if (we_i && (waddr_i == ROW_W'(g)))
        valid_q[g] <= 1'b1;
    end
  end

  always_comb begin
    int sub;
    in_range = 32'(raddr_i) < BYTES;
    rrow     = in_range ? ROW_W'(32'(raddr_i) / BPR) : '0;
    sub      = 32'(raddr_i) % BPR;
    sel_next = SEL_W'(BPR - 1 - sub);
  end

  always_ff @(posedge clk) begin
    word_q <= mem[rrow];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      sel_q <= '0;
    end else begin
      hit_q <= in_range && valid_q[rrow];
      sel_q <= sel_next;
    end
  end

  assign padded  = (BPR*8)'(word_q);
  assign rdata_o = hit_q ? padded[sel_q*8 +: 8] : 8'h00;
endmodule

// File: rtl/led_fault_scan.sv
module led_fault_scan
  import ledfault_pkg::*;
#(
  parameter int SINKS  = 16,
  parameter int ROWS   = 9,
  parameter int ROW_W  = $clog2(ROWS),
  parameter int ADDR_W = $clog2(ROWS * ((SINKS + 7) / 8))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              nine_row_i,
  input  logic [ROW_W-1:0]  row_idx_i,
  input  logic              frame_i,
  input  logic [SINKS-1:0]  open_flags_i,
  input  logic [SINKS-1:0]  short_flags_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              done_o
);
  localparam int BYTES = ROWS * ((SINKS + 7) / 8);

  logic             arm;
  fault_kind_t      kind;
  logic             clr;
  logic             we;
  logic [ROW_W-1:0] waddr;
  logic [SINKS-1:0] wdata;

  lf_arm_detect u_arm (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_i),
    .arm_o  (arm),
    .kind_o (kind)
  );

  lf_frame_seq #(.SINKS(SINKS), .ROW_W(ROW_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .arm_i         (arm),
    .kind_i        (kind),
    .nine_row_i    (nine_row_i),
    .row_idx_i     (row_idx_i),
    .frame_i       (frame_i),
    .open_flags_i  (open_flags_i),
    .short_flags_i (short_flags_i),
    .clr_o         (clr),
    .we_o          (we),
    .waddr_o       (waddr),
    .wdata_o       (wdata),
    .done_o        (done_o)
  );

  lf_status_bank #(
    .SINKS(SINKS), .ROWS(ROWS), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  initial begin
    if (BYTES > (1 << ADDR_W)) $error("read address too narrow");
  end
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int SINKS  = 16,
  parameter int BYTES  = 18,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_i,
  input logic              frame_i,
  input logic              nine_row_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic              done_o,
  input logic              arm,
  input logic              we,
  input logic [SINKS-1:0]  wdata
);
  AST_ARM_NEEDS_CODE: assert property (@(posedge clk) disable iff (rst)
    arm |-> ($past(mode_i) != 2'b00)); // R2

  AST_ARM_DROPS_DONE: assert property (@(posedge clk) disable iff (rst)
    arm |=> !done_o); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm) |=> done_o); // R9

  AST_DONE_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(frame_i)); // R3

  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !we); // R7

  AST_TOP_SINK_MASKED: assert property (@(posedge clk) disable iff (rst)
    (we && nine_row_i) |-> !wdata[SINKS-1]); // R8

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (32'($past(rd_addr_i)) >= BYTES) |-> (rd_data_o == 8'h00)); // R5
endmodule

bind led_fault_scan lf_checker #(
  .SINKS(SINKS), .BYTES(ROWS * ((SINKS + 7) / 8)), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_i     (mode_i),
  .frame_i    (frame_i),
  .nine_row_i (nine_row_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .done_o     (done_o),
  .arm        (arm),
  .we         (we),
  .wdata      (wdata)
);

// File: tb/sim_led_fault_scan.sv
module sim_led_fault_scan;
  localparam int SINKS  = 16;
  localparam int ROWS   = 9;
  localparam int ROW_W  = 4;
  localparam int ADDR_W = 5;
  localparam int BYTES  = 18;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        mode;
  logic              nine;
  logic [ROW_W-1:0]  row_idx;
  logic              frame;
  logic [SINKS-1:0]  oflags, sflags;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              done;

  int errors = 0;
  int checks = 0;
  int nrows;
  logic [SINKS-1:0] expw [ROWS];
  logic             pass_short;

  always #10 clk = ~clk; // 50 MHz

  led_fault_scan #(.SINKS(SINKS), .ROWS(ROWS)) u0 (
    .clk(clk), .rst(rst), .mode_i(mode), .nine_row_i(nine),
    .row_idx_i(row_idx), .frame_i(frame), .open_flags_i(oflags),
    .short_flags_i(sflags), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SINKS-1:0] pick(input logic is_short, input logic nr,
                                            input logic [SINKS-1:0] o, input logic [SINKS-1:0] s);
    logic [SINKS-1:0] w;
    w = is_short ? s : o;
    if (nr) w[SINKS-1] = 1'b0;
    return w;
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    if (a >= BYTES) return 8'h00;
    return (a % 2 == 0) ? expw[a/2][15:8] : expw[a/2][7:0];
  endfunction

  task automatic read_byte(input int a, output logic [7:0] d);
    @(negedge clk);
    frame = 1'b0;
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_bank(input string req);
    logic [7:0] d;
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      read_byte(a, d);
      chk(req, 32'(d), 32'(exp_byte(a)));
    end
  endtask

  // which: 0 = no record, 1 = record expected words, 2 = check done timing
  task automatic run_frame(input int which);
    int cyc = 0;
    for (int r = 0; r < nrows; r++) begin
      int len = 2 + int'($urandom % 3);
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        if (which == 2 && cyc == 0) chk("R3 done not early", 32'(done), 32'd0);
        if (which == 2 && cyc == 1) chk("R3/R9 done raised", 32'(done), 32'd1);
        row_idx = ROW_W'(r);
        frame   = (r == 0 && c == 0);
        oflags  = SINKS'($urandom);
        sflags  = SINKS'($urandom);
        if (which == 1 && c == len - 1) expw[r] = pick(pass_short, nine, oflags, sflags);
        cyc++;
      end
    end
  endtask

  task automatic arm(input logic [1:0] code);
    @(negedge clk);
    mode = 2'b00;
    repeat (2) @(negedge clk);
    mode = code;
    pass_short = (code == 2'b10);
    for (int r = 0; r < ROWS; r++) expw[r] = '0;
    repeat (4) @(negedge clk);
    chk("R9 done low after arm", 32'(done), 32'd0);
  endtask

  task automatic full_pass(input string req);
    run_frame(0);
    run_frame(1);
    run_frame(2);
    check_bank(req);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2718));
    rst = 1'b1; mode = 2'b00; nine = 1'b0; row_idx = '0; frame = 1'b0;
    oflags = '0; sflags = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 done after reset", 32'(done), 32'd0);
    for (int r = 0; r < ROWS; r++) expw[r] = '0;
    check_bank("R6 reset bank");

    // open pass, 8 rows scanned, row 8 stays clear
    nine = 1'b0; nrows = 8;
    arm(2'b01);
    full_pass("R1/R4/R5/R6 open 8 rows");

    // non-zero to non-zero must not re-arm; results frozen
    @(negedge clk); mode = 2'b11;
    repeat (4) @(negedge clk);
    run_frame(0); run_frame(0); run_frame(0);
    @(negedge clk);
    chk("R2 no rearm done", 32'(done), 32'd1);
    check_bank("R2/R7 frozen bank");

    // short pass, 9 rows with sink 16 reused as a row
    nine = 1'b1; nrows = 9;
    arm(2'b10);
    for (int a = 0; a < BYTES; a++) begin
      read_byte(a, d);
      chk("R6 cleared at arm", 32'(d), 32'd0);
    end
    full_pass("R1/R8 short 9 rows");

    // code 11 is open detection
    nine = 1'b0; nrows = 9;
    arm(2'b11);
    full_pass("R1 code 11 open");

    // random passes
    for (int k = 0; k < 4; k++) begin
      logic [1:0] code;
      code  = 2'(1 + ($urandom % 3));
      nine  = 1'($urandom);
      nrows = 1 + int'($urandom % ROWS);
      arm(code);
      full_pass("R1/R4/R5 random pass");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule